// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for a single memory burst. A one-cycle start pulse captures a starting column address, a length code and an ordering select. From the next clock on, the block presents one column address per cycle with a valid flag, and marks the final beat with a last flag. It does not move any data and has no memory array model.

The burst occupies an aligned window of 2, 4 or 8 columns. The starting low bits choose the window and the first position inside it. Two orderings are available. The wrapping ordering counts upward and folds back to the bottom of the window. The exclusive-or ordering combines the starting offset with the beat number. Column bits above the window keep the loaded value for the whole burst. A start that arrives while a burst is still running is dropped, unless it arrives on the final beat. In that case the next burst follows with no idle cycle.

Top module: `col_burst_seq`

## Requirements
- R1: While reset is asserted, and after it until the first accepted start, `valid_o` and `last_o` are both low.
- R2: A start is accepted when no burst is active. The clock edge that samples it loads the inputs. On the next cycle `valid_o` is high and `col_o` equals the captured `col_i` exactly.
- R3: With `ileave_i` = 0 (wrapping order), the in-window offset on beat k is (s + k) mod L, where s is the starting offset and L the length. Example: L = 4, s = 1 gives 1, 2, 3, 0.
- R4: With `ileave_i` = 1 (exclusive-or order), the in-window offset on beat k is s XOR k. Example: L = 8, s = 5 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R5: `len_i` encodes log2 of the length: 1 selects 2 beats, 2 selects 4 and 3 selects 8. Code 0 behaves as code 1. Every burst has exactly L valid beats.
- R6: The starting offset is `col_i[0]`, `col_i[1:0]` or `col_i[2:0]` for L = 2, 4 or 8. All `col_o` bits at or above bit log2(L) equal the captured `col_i` bits on every beat.
- R7: `last_o` is high only together with `valid_o`, on the final beat of a burst. On the cycle after the final beat, `valid_o` is low unless a new start was accepted on that final beat.
- R8: A start on a beat that is not the final one is ignored, and the running burst continues unchanged. A start on the final beat is accepted, and its first beat follows immediately.
- R9: For L = 2 both orders give the same sequence: 0, 1 from an even start and 1, 0 from an odd start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start pulse; captures `col_i`, `len_i`, `ileave_i` when accepted |
| col_i | input | COL_W | Starting column address |
| len_i | input | LEN_W | Length code, log2 of the beat count (0 treated as 1) |
| ileave_i | input | 1 | Order select: 0 wrapping, 1 exclusive-or |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final one of the burst |

## Verification
The bench builds the block with its default parameters: a 10-bit column and a largest window of 8 beats, which gives a 2-bit length code. At this size the bench covers every starting offset for every length code, including the aliased code 0, in both orders. The seven bits above the window carry random values, so any leak of the counter into them is detected. Holding start high for long stretches, with the inputs changing on every cycle, checks both that starts during a burst are dropped and that back-to-back bursts are accepted on the final beat.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic {
    ORD_WRAP = 1'b0,
    ORD_XOR  = 1'b1
  } order_e;

endpackage

// File: rtl/cbs_rst_sync.sv
module cbs_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/cbs_window_mask.sv
module cbs_window_mask #(
  parameter  int MAX_LOG = 3,
  localparam int LEN_W   = $clog2(MAX_LOG + 1)
) (
  input  logic [LEN_W-1:0]   len_code,
  output logic [MAX_LOG-1:0] mask
);

  logic [LEN_W-1:0] eff_log;

  always_comb begin
    if (len_code == '0) begin
      eff_log = LEN_W'(1);
    end else if (len_code > LEN_W'(MAX_LOG)) begin
      eff_log = LEN_W'(MAX_LOG);
    end else begin
      eff_log = len_code;
    end
  end

  for (genvar g = 0; g < MAX_LOG; g++) begin : g_bit
    assign mask[g] = (eff_log > LEN_W'(g));
  end

endmodule

// File: rtl/cbs_offset_gen.sv
module cbs_offset_gen
  import cbs_pkg::*;
#(
  parameter int MAX_LOG = 3
) (
  input  logic [MAX_LOG-1:0] start_ofs,
  input  logic [MAX_LOG-1:0] beat,
  input  logic [MAX_LOG-1:0] mask,
  input  order_e             order,
  output logic [MAX_LOG-1:0] ofs
);

  logic [MAX_LOG-1:0] wrap_sum;
  logic [MAX_LOG-1:0] xor_mix;

  always_comb begin
    wrap_sum = start_ofs + beat;
    xor_mix  = start_ofs ^ beat;
    if (order == ORD_XOR) begin
      ofs = xor_mix & mask;
    end else begin
      ofs = wrap_sum & mask;
    end
  end

endmodule

// File: rtl/cbs_beat_ctrl.sv
module cbs_beat_ctrl #(
  parameter int MAX_LOG = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [MAX_LOG-1:0] mask_q,
  output logic               accept_o,
  output logic               active_o,
  output logic               last_o,
  output logic [MAX_LOG-1:0] beat_o
);

  logic               active_q, active_d;
  logic [MAX_LOG-1:0] beat_q, beat_d;
  logic               final_beat;
  logic               accept;

  assign final_beat = active_q && (beat_q == mask_q);
  assign accept     = start_i && (!active_q || final_beat);

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    if (accept) begin
      active_d = 1'b1;
      beat_d   = '0;
    end else if (final_beat) begin
      active_d = 1'b0;
    end else if (active_q) begin
      beat_d = beat_q + MAX_LOG'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
    end
  end

  assign accept_o = accept;
  assign active_o = active_q;
  assign last_o   = final_beat;
  assign beat_o   = beat_q;

endmodule

// File: rtl/col_burst_seq.sv
module col_burst_seq
  import cbs_pkg::*;
#(
  parameter  int COL_W   = 10,
  parameter  int MAX_LOG = 3,
  localparam int LEN_W   = $clog2(MAX_LOG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ileave_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  localparam int UP_W = COL_W - MAX_LOG;

  logic               rst_n_s;
  logic               accept;
  logic               active;
  logic               last_w;
  logic [MAX_LOG-1:0] beat;
  logic [MAX_LOG-1:0] mask_d, mask_q;
  logic [MAX_LOG-1:0] ofs_w;
  logic [COL_W-1:0]   base_d, base_q;
  order_e             order_d, order_q;
  logic [COL_W-1:0]   win_full;

  cbs_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  cbs_window_mask #(.MAX_LOG(MAX_LOG)) u_mask (
    .len_code (len_i),
    .mask     (mask_d)
  );

  cbs_beat_ctrl #(.MAX_LOG(MAX_LOG)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (start_i),
    .mask_q   (mask_q),
    .accept_o (accept),
    .active_o (active),
    .last_o   (last_w),
    .beat_o   (beat)
  );

  always_comb begin
    base_d  = col_i;
    order_d = order_e'(ileave_i);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      base_q  <= '0;
      order_q <= ORD_WRAP;
      mask_q  <= '0;
    end else if (accept) begin
      base_q  <= base_d;
      order_q <= order_d;
      mask_q  <= mask_d;
    end
  end

  cbs_offset_gen #(.MAX_LOG(MAX_LOG)) u_ofs (
    .start_ofs (base_q[MAX_LOG-1:0]),
    .beat      (beat),
    .mask      (mask_q),
    .order     (order_q),
    .ofs       (ofs_w)
  );

  assign win_full = {{UP_W{1'b0}}, mask_q};
  assign col_o    = (base_q & ~win_full) | {{UP_W{1'b0}}, ofs_w};
  assign valid_o  = active;
  assign last_o   = last_w;

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int COL_W   = 10,
  parameter int MAX_LOG = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);

  logic [COL_W-MAX_LOG-1:0] upper;
  assign upper = col_o[COL_W-1:MAX_LOG];

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o); // R7

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (!valid_o || last_o) |=> valid_o && (col_o == $past(col_i))); // R2

  AST_END_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && last_o && !start_i |=> !valid_o); // R7

  AST_MID_CONTINUE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o |=> valid_o); // R8

  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o |=> $stable(upper)); // R6

  AST_BEAT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o |=> col_o != $past(col_o)); // R3

endmodule

bind col_burst_seq cbs_checker #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .start_i (start_i),
  .col_i   (col_i),
  .col_o   (col_o),
  .valid_o (valid_o),
  .last_o  (last_o)
);

// File: tb/tb_col_burst_seq.sv
`timescale 1ns/1ps
module tb_col_burst_seq;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [COL_W-1:0] col;
  logic [1:0]       len;
  logic             ilv;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  bit ign_pending = 0;
  int addr_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  col_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .col_i(col), .len_i(len),
    .ileave_i(ilv), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  // Reference model: a queue of expected addresses, head = current beat.
  always @(posedge clk) begin
    if (!rst_n) begin
      addr_q.delete(); tag_q.delete(); ign_pending = 0;
    end else begin
      bit acc;
      acc = start && (addr_q.size() <= 1);
      if (start && !acc) ign_pending = 1;
      if (addr_q.size() > 0) begin
        void'(addr_q.pop_front()); void'(tag_q.pop_front());
      end
      if (addr_q.size() == 0) ign_pending = 0;
      if (acc) begin
        int lg, bl, s, c;
        lg = (len == 0) ? 1 : int'(len);
        bl = 1 << lg;
        c  = int'(col);
        s  = c & (bl - 1);
        for (int k = 0; k < bl; k++) begin
          int off;
          off = ilv ? (s ^ k) : ((s + k) % bl);
          addr_q.push_back((c & ~(bl - 1)) | off);
          if (k == 0)        tag_q.push_back("R2");
          else if (len == 0) tag_q.push_back("R5");
          else if (bl == 2)  tag_q.push_back("R9");
          else if (ilv)      tag_q.push_back("R4");
          else               tag_q.push_back("R3");
        end
      end
    end
  end

  // Compare on every falling edge once out of reset.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev, el;
      ev = addr_q.size() > 0;
      el = addr_q.size() == 1;
      vectors++;
      if (valid_o !== ev || last_o !== el) begin
        fails++;
        $display("FAIL %s valid/last: got %b/%b exp %b/%b at %0t",
                 ign_pending ? "R8" : "R7", valid_o, last_o, ev, el, $time);
      end else if (ev && int'(col_o) != addr_q[0]) begin
        string t;
        if (((int'(col_o) ^ addr_q[0]) >> 3) != 0) t = "R6";
        else if (ign_pending) t = "R8";
        else t = tag_q[0];
        fails++;
        $display("FAIL %s col: got %0d exp %0d at %0t", t, col_o, addr_q[0], $time);
      end
    end
  end

  task automatic issue(input logic [COL_W-1:0] c, input logic [1:0] l, input logic i);
    @(negedge clk);
    start = 1'b1; col = c; len = l; ilv = i;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired, burst sequence never completed");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; col = '0; len = 2'd0; ilv = 1'b0;
    // R1: outputs idle while reset is held
    repeat (4) begin
      @(negedge clk);
      vectors++;
      if (valid_o !== 1'b0 || last_o !== 1'b0) begin
        fails++;
        $display("FAIL R1 reset: got valid %b last %b exp 0/0", valid_o, last_o);
      end
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);   // idle after release also checked (R1)

    // Every start offset, every length code (R5 aliases 0), both orders (R3, R4, R9)
    for (int l = 0; l < 4; l++) begin
      for (int i = 0; i < 2; i++) begin
        for (int s = 0; s < 8; s++) begin
          issue(COL_W'(($urandom_range(0, 127) << 3) | s), 2'(l), 1'(i));
          repeat (9) @(negedge clk);
        end
      end
    end

    // Start held high with changing inputs: mid-burst ignore and accept on last (R8)
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      start = 1'b1;
      repeat (40) begin
        col = COL_W'($urandom_range(0, 1023));
        len = 2'($urandom_range(0, 3));
        ilv = 1'($urandom_range(0, 1));
        @(negedge clk);
      end
      start = 1'b0;
      repeat (10) @(negedge clk);
    end

    // Random starts with random gaps (R2..R9)
    repeat (600) begin
      @(negedge clk);
      start = ($urandom_range(0, 3) == 0);
      col   = COL_W'($urandom_range(0, 1023));
      len   = 2'($urandom_range(0, 3));
      ilv   = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    finish_run();
  end

endmodule